// File: doc/BRIEF.md
# Edge Phase Comparator with Lock Mask

This block sits in the speed loop of a brushless spindle drive. It watches two pulse trains: a reference clock that sets the target rotation rate, and a speed feedback pulse (fg) taken from the first Hall sensor channel. On every pair of rising edges it produces a phase-error pulse. While the reference edge leads, `pd_up` is high until the feedback edge arrives. While the feedback edge leads, `pd_dn` is high until the reference edge arrives. The width of the pulse is the phase error in system-clock ticks, and an external loop filter turns it into a torque command.

The comparison is graded against a tolerance window. A run of consecutive comparisons inside the window declares an internal raw lock. The `lock` output can be held back by a programmable mask time (`mask_cycles`), so that short drop-outs while the loop hunts into lock are not seen outside. When the mask is zero, `lock` tracks raw lock directly.

The block also measures the period between feedback edges against the reference period. It raises `near_speed` once the motor exceeds 95 percent of its target rate, which the current controller uses to cap the drive current at 87.5 percent. A low `run` input clears all state.

Top module: `phase_edge_lock`

## Requirements
- R1: Both pulse inputs pass through a two-flop synchronizer, and only their rising edges take part in a comparison. A falling edge on either input starts or ends no error pulse.
- R2: After a reference rising edge, `pd_up` is high for exactly as many cycles as the feedback rising edge lags it. After a feedback rising edge, `pd_dn` is high for exactly as many cycles as the reference rising edge lags it. Coincident edges give no pulse. The two outputs are never high together.
- R3: A comparison is good when its error pulse lasts at most WIN_TICKS cycles (default 4). After LOCK_N consecutive good comparisons (default 4), raw lock is declared. An error pulse that grows past WIN_TICKS cancels raw lock at once.
- R4: `lock` is high only in a cycle after one in which raw lock held. A single comparison outside the window drops `lock` within a few cycles.
- R5: With `mask_cycles` = M > 0, `lock` rises only after raw lock has held for M consecutive cycles. Any drop of raw lock restarts that count.
- R6: With `mask_cycles` = 0, `lock` equals raw lock delayed by one cycle.
- R7: `near_speed` is updated on each feedback rising edge after the first. It is set when 19 × (feedback period) < 20 × (reference period) and cleared otherwise. Both periods are measured in cycles between consecutive rising edges. It stays low until a reference period has been measured.
- R8: When `run` is low, all four outputs are low in the following cycle and all internal state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable; low clears the comparator |
| clk_ref | input | 1 | Reference speed clock (asynchronous) |
| fg | input | 1 | Speed feedback pulse from Hall channel 1 (asynchronous) |
| mask_cycles | input | MASK_W | Lock mask time in system cycles; 0 disables masking |
| pd_up | output | 1 | Error pulse while the reference edge leads |
| pd_dn | output | 1 | Error pulse while the feedback edge leads |
| lock | output | 1 | High while the loop is phase locked (after masking) |
| near_speed | output | 1 | High when speed exceeds 95 percent of target |

## Verification
Equal-period trains are applied with the feedback lagging, the feedback leading, and the two coincident. These tell the polarity of the error pulse apart from its width, and from the absence of any pulse. Lag offsets of 3, 4 and 5 ticks place the window limit between a kept lock and a lost lock. Single bad comparisons injected mid-run, with the mask at zero and at 300 cycles, separate an immediate drop from a masked restart. Period pairs on either side of the 19:20 ratio, including the exact equality, decide `near_speed`. A sequence made only of falling edges shows that falling edges have no effect.

// File: rtl/phase_edge_lock_pkg.sv
package phase_edge_lock_pkg;
  // speed threshold: fg period * NUM < ref period * DEN means > 95 % speed
  localparam int unsigned SPD_NUM = 19;
  localparam int unsigned SPD_DEN = 20;
  localparam int unsigned SPD_EXT = 5;  // extra product bits for 19/20
endpackage

// File: rtl/phase_edge_lock_edge.sv
module phase_edge_lock_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/phase_edge_lock_pfd.sv
module phase_edge_lock_pfd #(
  parameter int unsigned WIN_TICKS = 4,
  parameter int unsigned LOCK_N    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_rise,
  input  logic fg_rise,
  output logic up,
  output logic dn,
  output logic raw_lock
);
  localparam int unsigned WW   = $clog2(WIN_TICKS + 2);
  localparam int unsigned GW   = $clog2(LOCK_N + 1);
  localparam logic [WW-1:0] WMAX = WW'(WIN_TICKS + 1);
  localparam logic [WW-1:0] WLIM = WW'(WIN_TICKS);
  localparam logic [GW-1:0] GMAX = GW'(LOCK_N);

  logic [WW-1:0] width;
  logic [GW-1:0] good;
  logic nu, nd, close, too_wide;

  always_comb begin
    nu       = up | ref_rise;
    nd       = dn | fg_rise;
    close    = nu & nd;
    too_wide = width > WLIM;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      up    <= 1'b0;
      dn    <= 1'b0;
      width <= '0;
      good  <= '0;
    end else if (close) begin
      up    <= 1'b0;
      dn    <= 1'b0;
      width <= '0;
      if (width <= WLIM) good <= (good == GMAX) ? good : good + 1'b1;
      else               good <= '0;
    end else begin
      up <= nu;
      dn <= nd;
      if ((nu | nd) && width != WMAX) width <= width + 1'b1;
      if (too_wide) good <= '0;
    end
  end

  assign raw_lock = (good == GMAX);
endmodule

// File: rtl/phase_edge_lock_mask.sv
module phase_edge_lock_mask #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              raw_lock,
  input  logic [MASK_W-1:0] mask_cycles,
  output logic              lock
);
  localparam logic [MASK_W-1:0] MMAX = '1;
  logic [MASK_W-1:0] mcnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      mcnt <= '0;
      lock <= 1'b0;
    end else begin
      if (!raw_lock)         mcnt <= '0;
      else if (mcnt != MMAX) mcnt <= mcnt + 1'b1;
      lock <= raw_lock && (mcnt >= mask_cycles);
    end
  end
endmodule

// File: rtl/phase_edge_lock_speed.sv
module phase_edge_lock_speed
  import phase_edge_lock_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic ref_rise,
  input  logic fg_rise,
  output logic near_speed
);
  localparam int unsigned PW = CNT_W + SPD_EXT;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] r_cnt, r_per, f_cnt;
  logic r_seen, f_seen;
  logic [PW-1:0] lhs, rhs;

  always_comb begin
    lhs = PW'(f_cnt) * PW'(SPD_NUM);
    rhs = PW'(r_per) * PW'(SPD_DEN);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      r_cnt <= '0; r_per <= '0; r_seen <= 1'b0;
      f_cnt <= '0; f_seen <= 1'b0; near_speed <= 1'b0;
    end else begin
      if (ref_rise) begin
        r_cnt  <= CNT_W'(1);
        r_seen <= 1'b1;
        if (r_seen) r_per <= r_cnt;
      end else if (r_cnt != CMAX) begin
        r_cnt <= r_cnt + 1'b1;
      end
      if (fg_rise) begin
        f_cnt  <= CNT_W'(1);
        f_seen <= 1'b1;
        if (f_seen) near_speed <= (lhs < rhs);
      end else if (f_cnt != CMAX) begin
        f_cnt <= f_cnt + 1'b1;
      end else begin
        near_speed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/phase_edge_lock.sv
module phase_edge_lock #(
  parameter int unsigned WIN_TICKS = 4,
  parameter int unsigned LOCK_N    = 4,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned MASK_W    = 16,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              clk_ref,
  input  logic              fg,
  input  logic [MASK_W-1:0] mask_cycles,
  output logic              pd_up,
  output logic              pd_dn,
  output logic              lock,
  output logic              near_speed
);
  localparam int unsigned NIN = 2;
  logic [NIN-1:0] pins, rises;
  logic ref_rise, fg_rise, raw_lock;

  assign pins = {fg, clk_ref};

  for (genvar g = 0; g < NIN; g++) begin : g_edge
    phase_edge_lock_edge #(.STAGES(SYNC_N)) u_edge (
      .clk(clk), .rst(rst), .din(pins[g]), .rise(rises[g])
    );
  end

  assign ref_rise = rises[0];
  assign fg_rise  = rises[1];

  phase_edge_lock_pfd #(.WIN_TICKS(WIN_TICKS), .LOCK_N(LOCK_N)) u_pfd (
    .clk(clk), .rst(rst), .run(run), .ref_rise(ref_rise), .fg_rise(fg_rise),
    .up(pd_up), .dn(pd_dn), .raw_lock(raw_lock)
  );

  phase_edge_lock_mask #(.MASK_W(MASK_W)) u_mask (
    .clk(clk), .rst(rst), .run(run), .raw_lock(raw_lock),
    .mask_cycles(mask_cycles), .lock(lock)
  );

  phase_edge_lock_speed #(.CNT_W(CNT_W)) u_speed (
    .clk(clk), .rst(rst), .run(run), .ref_rise(ref_rise), .fg_rise(fg_rise),
    .near_speed(near_speed)
  );
endmodule

// File: rtl/phase_edge_lock_chk.sv
module phase_edge_lock_chk #(
  parameter int unsigned MASK_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [MASK_W-1:0] mask_cycles,
  input logic              pd_up,
  input logic              pd_dn,
  input logic              lock,
  input logic              near_speed,
  input logic              raw_lock,
  input logic              fg_rise
);
  p_pd_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(pd_up && pd_dn));

  p_lock_from_raw_r4: assert property (@(posedge clk) disable iff (rst)
    lock |-> $past(raw_lock));

  p_nomask_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (run && mask_cycles == '0) |=> (lock == $past(raw_lock)));

  p_near_on_fg_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(near_speed) |-> ($past(fg_rise) || !$past(run)));

  p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!pd_up && !pd_dn && !lock && !near_speed));
endmodule

bind phase_edge_lock phase_edge_lock_chk #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .mask_cycles(mask_cycles),
  .pd_up(pd_up), .pd_dn(pd_dn), .lock(lock), .near_speed(near_speed),
  .raw_lock(raw_lock), .fg_rise(fg_rise)
);

// File: tb/phase_edge_lock_bench.sv
module phase_edge_lock_bench;
  localparam int MW = 16;
  logic clk = 1'b0, rst = 1'b1, run = 1'b0, clk_ref = 1'b0, fg = 1'b0;
  logic [MW-1:0] mask_cycles = '0;
  logic pd_up, pd_dn, lock, near_speed;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  phase_edge_lock u_phase_edge_lock (
    .clk(clk), .rst(rst), .run(run), .clk_ref(clk_ref), .fg(fg),
    .mask_cycles(mask_cycles), .pd_up(pd_up), .pd_dn(pd_dn),
    .lock(lock), .near_speed(near_speed)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int mask);
    @(negedge clk);
    rst = 1'b1; run = 1'b1; clk_ref = 1'b0; fg = 1'b0;
    mask_cycles = MW'(mask);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // drives ref with period pr and fg with period pf; fg edge j may use gofs
  task automatic run_pat(input int pr, input int pf, input int rofs,
                         input int fofs, input int gj, input int gofs,
                         input int n, input int probe_at,
                         output int ups, output int dns, output int probe_lock);
    ups = 0; dns = 0; probe_lock = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pd_up) ups++;
      if (pd_dn) dns++;
      if (i == probe_at) probe_lock = int'(lock);
      clk_ref = (i % pr) >= (pr / 2 + rofs);
      fg = (i % pf) >= (pf / 2 + (((i / pf) == gj) ? gofs : fofs));
    end
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (pd_up) ups++;
      if (pd_dn) dns++;
    end
  endtask

  task automatic t_reset();
    do_reset(0);
    @(negedge clk);
    check("R8 reset pd_up", int'(pd_up), 0);
    check("R8 reset pd_dn", int'(pd_dn), 0);
    check("R8 reset lock", int'(lock), 0);
    check("R8 reset near", int'(near_speed), 0);
  endtask

  task automatic t_lag(input int ofs, input int exp_lock);
    int u, d, p;
    do_reset(0);
    run_pat(40, 40, 0, ofs, -1, 0, 400, -1, u, d, p);
    check($sformatf("R2 lag%0d up width", ofs), u, 10 * ofs);
    check($sformatf("R2 lag%0d no dn", ofs), d, 0);
    check($sformatf("R3 lag%0d lock", ofs), int'(lock), exp_lock);
  endtask

  task automatic t_lead();
    int u, d, p;
    do_reset(0);
    run_pat(40, 40, 2, 0, -1, 0, 400, -1, u, d, p);
    check("R2 lead dn width", d, 20);
    check("R2 lead no up", u, 0);
    check("R3 lead lock", int'(lock), 1);
  endtask

  task automatic t_coincident();
    int u, d, p;
    do_reset(0);
    run_pat(40, 40, 0, 0, -1, 0, 400, 330, u, d, p);
    check("R2 coincident no pulse", u + d, 0);
    check("R6 nomask lock early", p, 1);
    check("R7 equal periods near", int'(near_speed), 1);
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    check("R8 run low clears lock", int'(lock), 0);
    check("R8 run low clears near", int'(near_speed), 0);
    run = 1'b1;
  endtask

  task automatic t_falling();
    int u;
    do_reset(0);
    @(negedge clk); clk_ref = 1'b1; fg = 1'b1;
    repeat (10) @(negedge clk);
    u = 0;
    clk_ref = 1'b0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (pd_up || pd_dn) u++; end
    fg = 1'b0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); if (pd_up || pd_dn) u++; end
    check("R1 falling edges ignored", u, 0);
    clk_ref = 1'b1;
    u = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k == 2) fg = 1'b1;
      if (pd_up) u++;
    end
    check("R1 rising edges compared", u, 3);
  endtask

  task automatic t_nomask_glitch();
    int u, d, p;
    do_reset(0);
    run_pat(40, 40, 0, 0, 8, 7, 600, 354, u, d, p);
    check("R4 bad compare drops lock", p, 0);
    check("R4 lock regained", int'(lock), 1);
  endtask

  task automatic t_mask();
    int u, d, p;
    do_reset(300);
    run_pat(40, 40, 0, 0, -1, 0, 800, 300, u, d, p);
    check("R5 mask delays lock", p, 0);
    check("R5 mask lock after", int'(lock), 1);
    do_reset(300);
    run_pat(40, 40, 0, 0, -1, 0, 600, 520, u, d, p);
    check("R5 mask elapsed lock", p, 1);
    do_reset(300);
    run_pat(40, 40, 0, 0, 8, 7, 1200, 520, u, d, p);
    check("R5 glitch restarts mask", p, 0);
    check("R5 glitch lock final", int'(lock), 1);
  endtask

  task automatic t_speed(input int pr, input int pf, input int exp);
    int u, d, p;
    do_reset(0);
    run_pat(pr, pf, 0, 0, -1, 0, 20 * pf, -1, u, d, p);
    check($sformatf("R7 near ref%0d fg%0d", pr, pf), int'(near_speed), exp);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_lag(3, 1);
    t_lag(4, 1);
    t_lag(5, 0);
    t_lead();
    t_coincident();
    t_falling();
    t_nomask_glitch();
    t_mask();
    t_speed(40, 41, 1);
    t_speed(40, 43, 0);
    t_speed(38, 40, 0);
    t_speed(38, 39, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule